// File: doc/BRIEF.md
# Horizontal Output Timing Generator

This block produces the horizontal timing of one video output line from a pixel-rate line counter. It drives a sync pulse of fixed width and selectable polarity, a line reference strobe that frames the displayed part of the line, and an active-pixel strobe that frames the pixels carrying picture data. Displayed pixels that are not active pixels are flagged as border, and the programmed Y, U and V border values are presented on dedicated outputs so that a downstream multiplexer can insert them.

The line counter has two sources of line restart. In free-running mode it wraps after a programmed number of pixel clocks. In locked mode it restarts on the rising edge of an external horizontal sync, which is first passed through a two-flop synchronizer; without a sync it parks at its maximum value. All timing settings are captured at the start of a line, so every line is produced from one consistent set. The mode bit itself is used live, so that a parked counter can always be released into free-running mode.

Positions in a line are counted from 0 at the first clock of the line. A position p is presented on the outputs one clock later, because all outputs are registered.

Top module: `hout_timing_gen`

## Requirements
- R1: With `free_run` = 0, a rising edge of `hsync_in` first sampled high at clock edge e restarts the line so that `hsync_o` shows its active level from clock edge e+3 on (the fourth edge counting e).
- R2: With `free_run` = 1, the line restarts every `line_len` clocks (valid range 65 to 2^W-1).
- R3: The sync output holds its active level for exactly 64 clocks at positions 0 to 63 of each line.
- R4: With `sync_inv` = 0 the active sync level is 1; with `sync_inv` = 1 it is 0.
- R5: `lref_o` is high for positions p with S <= p < S + `disp_len`, where S = `ref_delay` + 36.
- R6: `bdr_sel_o` is high exactly when `lref_o` is high and `act_o` is low; while it is high the border colour outputs carry the latched Y/U/V border values, otherwise they are 0.
- R7: `act_o` is high for positions p with S + `border_w` + `trim` <= p and p + `trim` < S + `border_w` + `act_len`, inside the displayed window; with 2*`trim` >= `act_len` it never asserts.
- R8: `act_o` is never high while `lref_o` is low.
- R9: In locked mode without an input sync the counter stops at 2^W-1 and stays there; at that position both strobes and the border select are low.
- R10: Every setting except `free_run` is captured at the clock edge that starts a line (and during reset); a change in mid-line affects only the following lines.
- R11: A displayed or active window reaching beyond the end of the line is cut off at the line restart.
- R12: While `rst` is high, `hsync_o` sits at its inactive level (equal to `sync_inv`) and all strobes and colour outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Incoming horizontal sync, asynchronous |
| free_run | input | 1 | 1: free-running, 0: locked to `hsync_in` |
| sync_inv | input | 1 | Sync polarity, 1 inverts the output |
| line_len | input | W | Clocks per line in free-running mode |
| ref_delay | input | W | Programmable part of the sync-to-reference delay |
| disp_len | input | W | Displayed pixels per line |
| border_w | input | W | Border pixels before the active pixels |
| act_len | input | W | Active pixels per line before trimming |
| trim | input | W | Symmetric trim of the active window |
| bdr_y_in | input | C | Border luma value |
| bdr_u_in | input | C | Border U value |
| bdr_v_in | input | C | Border V value |
| hsync_o | output | 1 | Output horizontal sync |
| lref_o | output | 1 | Displayed-window strobe |
| act_o | output | 1 | Active-pixel strobe |
| bdr_sel_o | output | 1 | Border colour select |
| bdr_y_o | output | C | Border luma while selected, else 0 |
| bdr_u_o | output | C | Border U while selected, else 0 |
| bdr_v_o | output | C | Border V while selected, else 0 |

## Verification
The free-running restart check assumes `line_len` stays between 65 and 2^W-1, so the counter never reaches its parking value in that mode and the 64-clock sync fits in every line; the stimulus uses lengths of 100 and 150 with W = 9. In locked mode the sync-width property presumes input syncs at least 65 clocks apart, and the stimulus spaces them 70 clocks or more. The window properties take no assumption on the delay, border, active and trim values, so the sweeps include windows that overrun the line and trims that empty the active window, with settings changed in mid-line.

// File: rtl/hout_pkg.sv
package hout_pkg;

  // Width of the output sync pulse in pixel clocks.
  localparam int unsigned SYNC_CLKS = 64;
  // Fixed latency of the pixel pipeline between sync and reference strobe.
  localparam int unsigned PROC_DLY  = 36;

  // Classification of one pixel position.
  typedef enum logic [1:0] {
    ZN_OFF    = 2'd0,
    ZN_BORDER = 2'd1,
    ZN_ACTIVE = 2'd2
  } zone_e;

endpackage

// File: rtl/hout_sync_detect.sv
module hout_sync_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/hout_line_counter.sv
module hout_line_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         free_run,
  input  logic         sync_rise,
  input  logic [W-1:0] len_q,
  output logic [W-1:0] pos_o,
  output logic         restart_o,
  output logic         sat_o
);

  localparam logic [W-1:0] POS_MAX = {W{1'b1}};

  logic [W:0] pos_next_ext;
  logic       wrap_free;

  always_comb begin
    pos_next_ext = {1'b0, pos_o} + {{W{1'b0}}, 1'b1};
    wrap_free    = (pos_next_ext >= {1'b0, len_q});
    restart_o    = free_run ? wrap_free : sync_rise;
    sat_o        = (pos_o == POS_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst)            pos_o <= '0;
    else if (restart_o) pos_o <= '0;
    else if (!sat_o)    pos_o <= pos_o + 1'b1;
  end

  AST_LOCK_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!free_run && sync_rise) |=> (pos_o == '0));                               // R1

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
    (free_run && ({1'b0, pos_o} + 1'b1 < {1'b0, len_q})) |=> (pos_o == $past(pos_o) + 1'b1)); // R2

  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!free_run && !sync_rise && pos_o == POS_MAX) |=> (pos_o == POS_MAX));     // R9

endmodule

// File: rtl/hout_cfg_latch.sv
module hout_cfg_latch #(
  parameter int W = 12,
  parameter int C = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic         inv_in,
  input  logic [W-1:0] len_in,
  input  logic [W-1:0] dly_in,
  input  logic [W-1:0] disp_in,
  input  logic [W-1:0] bw_in,
  input  logic [W-1:0] act_in,
  input  logic [W-1:0] trim_in,
  input  logic [C-1:0] y_in,
  input  logic [C-1:0] u_in,
  input  logic [C-1:0] v_in,
  output logic         inv_q,
  output logic [W-1:0] len_q,
  output logic [W-1:0] dly_q,
  output logic [W-1:0] disp_q,
  output logic [W-1:0] bw_q,
  output logic [W-1:0] act_q,
  output logic [W-1:0] trim_q,
  output logic [C-1:0] y_q,
  output logic [C-1:0] u_q,
  output logic [C-1:0] v_q
);

  always_ff @(posedge clk) begin
    if (load) begin
      inv_q  <= inv_in;
      len_q  <= len_in;
      dly_q  <= dly_in;
      disp_q <= disp_in;
      bw_q   <= bw_in;
      act_q  <= act_in;
      trim_q <= trim_in;
      y_q    <= y_in;
      u_q    <= u_in;
      v_q    <= v_in;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (load)
    1'b1 |=> ($stable(len_q) && $stable(dly_q) && $stable(disp_q) && $stable(bw_q)
              && $stable(act_q) && $stable(trim_q) && $stable(inv_q)));         // R10

endmodule

// File: rtl/hout_window_decode.sv
module hout_window_decode
  import hout_pkg::*;
#(
  parameter int W = 12,
  parameter int C = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rst_inv,
  input  logic [W-1:0] pos,
  input  logic         sat,
  input  logic         inv_q,
  input  logic [W-1:0] dly_q,
  input  logic [W-1:0] disp_q,
  input  logic [W-1:0] bw_q,
  input  logic [W-1:0] act_q,
  input  logic [W-1:0] trim_q,
  input  logic [C-1:0] y_q,
  input  logic [C-1:0] u_q,
  input  logic [C-1:0] v_q,
  output logic         hsync_o,
  output logic         lref_o,
  output logic         act_o,
  output logic         bdr_sel_o,
  output logic [C-1:0] bdr_y_o,
  output logic [C-1:0] bdr_u_o,
  output logic [C-1:0] bdr_v_o
);

  // Wide enough that no sum of four W-bit terms plus the delay overflows.
  localparam int EW = W + 3;
  localparam logic [EW-1:0] SYNC_E = EW'(SYNC_CLKS);
  localparam logic [EW-1:0] PD_E   = EW'(PROC_DLY);

  logic [EW-1:0] p_e, ref_start, ref_stop, act_start, act_limit, p_trim;
  logic          in_ref, in_act, hs_lvl;
  zone_e         zone;

  always_comb begin
    p_e       = EW'(pos);
    ref_start = EW'(dly_q) + PD_E;
    ref_stop  = ref_start + EW'(disp_q);
    act_start = ref_start + EW'(bw_q) + EW'(trim_q);
    act_limit = ref_start + EW'(bw_q) + EW'(act_q);
    p_trim    = p_e + EW'(trim_q);
    in_ref    = !sat && (p_e >= ref_start) && (p_e < ref_stop);
    in_act    = (p_e >= act_start) && (p_trim < act_limit);
    if (!in_ref)     zone = ZN_OFF;
    else if (in_act) zone = ZN_ACTIVE;
    else             zone = ZN_BORDER;
    hs_lvl    = (p_e < SYNC_E) ^ inv_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o   <= rst_inv;
      lref_o    <= 1'b0;
      act_o     <= 1'b0;
      bdr_sel_o <= 1'b0;
      bdr_y_o   <= '0;
      bdr_u_o   <= '0;
      bdr_v_o   <= '0;
    end else begin
      hsync_o   <= hs_lvl;
      lref_o    <= (zone != ZN_OFF);
      act_o     <= (zone == ZN_ACTIVE);
      bdr_sel_o <= (zone == ZN_BORDER);
      bdr_y_o   <= (zone == ZN_BORDER) ? y_q : '0;
      bdr_u_o   <= (zone == ZN_BORDER) ? u_q : '0;
      bdr_v_o   <= (zone == ZN_BORDER) ? v_q : '0;
    end
  end

  // Run length of the active sync level as seen on the output pin.
  logic       inv_d;
  logic [7:0] hs_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_d  <= rst_inv;
      hs_run <= '0;
    end else begin
      inv_d  <= inv_q;
      if (hsync_o ^ inv_d) hs_run <= (hs_run == 8'hFF) ? hs_run : hs_run + 1'b1;
      else                 hs_run <= '0;
    end
  end

  AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (rst)
    hs_run <= 8'(SYNC_CLKS));                                                  // R3

  AST_ACT_IN_REF: assert property (@(posedge clk) disable iff (rst)
    act_o |-> lref_o);                                                         // R8

  AST_BORDER_SEL: assert property (@(posedge clk) disable iff (rst)
    bdr_sel_o |-> (lref_o && !act_o));                                         // R6

  AST_COLOUR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bdr_sel_o |-> (bdr_y_o == '0 && bdr_u_o == '0 && bdr_v_o == '0));         // R6

  AST_PARK_QUIET: assert property (@(posedge clk) disable iff (rst)
    sat |=> (!lref_o && !act_o && !bdr_sel_o));                                // R9

endmodule

// File: rtl/hout_timing_gen.sv
module hout_timing_gen #(
  parameter int W          = 12,
  parameter int C          = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hsync_in,
  input  logic         free_run,
  input  logic         sync_inv,
  input  logic [W-1:0] line_len,
  input  logic [W-1:0] ref_delay,
  input  logic [W-1:0] disp_len,
  input  logic [W-1:0] border_w,
  input  logic [W-1:0] act_len,
  input  logic [W-1:0] trim,
  input  logic [C-1:0] bdr_y_in,
  input  logic [C-1:0] bdr_u_in,
  input  logic [C-1:0] bdr_v_in,
  output logic         hsync_o,
  output logic         lref_o,
  output logic         act_o,
  output logic         bdr_sel_o,
  output logic [C-1:0] bdr_y_o,
  output logic [C-1:0] bdr_u_o,
  output logic [C-1:0] bdr_v_o
);

  logic         sync_rise, restart, sat;
  logic [W-1:0] pos;
  logic         inv_q;
  logic [W-1:0] len_q, dly_q, disp_q, bw_q, act_q, trim_q;
  logic [C-1:0] y_q, u_q, v_q;

  hout_sync_detect #(.STAGES(SYNC_STAGE)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (hsync_in),
    .rise_o   (sync_rise)
  );

  hout_line_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .free_run  (free_run),
    .sync_rise (sync_rise),
    .len_q     (len_q),
    .pos_o     (pos),
    .restart_o (restart),
    .sat_o     (sat)
  );

  hout_cfg_latch #(.W(W), .C(C)) u_cfg (
    .clk     (clk),
    .load    (rst | restart),
    .inv_in  (sync_inv),
    .len_in  (line_len),
    .dly_in  (ref_delay),
    .disp_in (disp_len),
    .bw_in   (border_w),
    .act_in  (act_len),
    .trim_in (trim),
    .y_in    (bdr_y_in),
    .u_in    (bdr_u_in),
    .v_in    (bdr_v_in),
    .inv_q   (inv_q),
    .len_q   (len_q),
    .dly_q   (dly_q),
    .disp_q  (disp_q),
    .bw_q    (bw_q),
    .act_q   (act_q),
    .trim_q  (trim_q),
    .y_q     (y_q),
    .u_q     (u_q),
    .v_q     (v_q)
  );

  hout_window_decode #(.W(W), .C(C)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .rst_inv   (sync_inv),
    .pos       (pos),
    .sat       (sat),
    .inv_q     (inv_q),
    .dly_q     (dly_q),
    .disp_q    (disp_q),
    .bw_q      (bw_q),
    .act_q     (act_q),
    .trim_q    (trim_q),
    .y_q       (y_q),
    .u_q       (u_q),
    .v_q       (v_q),
    .hsync_o   (hsync_o),
    .lref_o    (lref_o),
    .act_o     (act_o),
    .bdr_sel_o (bdr_sel_o),
    .bdr_y_o   (bdr_y_o),
    .bdr_u_o   (bdr_u_o),
    .bdr_v_o   (bdr_v_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!lref_o && !act_o && !bdr_sel_o && hsync_o == $past(sync_inv))); // R12

endmodule

// File: tb/tb_hout_timing_gen.sv
module tb_hout_timing_gen;

  localparam int W    = 9;
  localparam int C    = 8;
  localparam int MAXP = (1 << W) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic         rst, hsync_in, free_run, sync_inv;
  logic [W-1:0] line_len, ref_delay, disp_len, border_w, act_len, trim;
  logic [C-1:0] bdr_y_in, bdr_u_in, bdr_v_in;
  logic         hsync_o, lref_o, act_o, bdr_sel_o;
  logic [C-1:0] bdr_y_o, bdr_u_o, bdr_v_o;

  hout_timing_gen #(.W(W), .C(C)) dut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .free_run(free_run), .sync_inv(sync_inv),
    .line_len(line_len), .ref_delay(ref_delay), .disp_len(disp_len), .border_w(border_w),
    .act_len(act_len), .trim(trim), .bdr_y_in(bdr_y_in), .bdr_u_in(bdr_u_in),
    .bdr_v_in(bdr_v_in), .hsync_o(hsync_o), .lref_o(lref_o), .act_o(act_o),
    .bdr_sel_o(bdr_sel_o), .bdr_y_o(bdr_y_o), .bdr_u_o(bdr_u_o), .bdr_v_o(bdr_v_o)
  );

  int    errors = 0;
  int    checks = 0;
  string scen   = "R12";
  bit    done   = 0;

  // Requirement-level model of the line: position, settings captured at line start,
  // and the two-flop input synchronizer with its edge memory.
  int m_pos, m_len, m_dly, m_disp, m_bw, m_act, m_trim, m_inv, m_y, m_u, m_v;
  bit s1, s2, s3;

  task automatic capture();
    m_len = line_len; m_dly = ref_delay; m_disp = disp_len; m_bw = border_w;
    m_act = act_len;  m_trim = trim;     m_inv = sync_inv;
    m_y = bdr_y_in;   m_u = bdr_u_in;    m_v = bdr_v_in;
  endtask

  task automatic check(string sig, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", scen, sig, actual, expected, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One clock: model the edge that just passed, compare, leave inputs to the caller.
  task automatic step();
    int e_hs, e_ref, e_act, e_sel, s, rs;
    bit rise, restart, in_act;
    @(negedge clk);
    if (rst) begin
      e_hs = sync_inv; e_ref = 0; e_act = 0; e_sel = 0;    // R12
      m_pos = 0; s1 = 0; s2 = 0; s3 = 0;
      capture();
    end else begin
      s      = m_dly + 36;                                 // R5
      rs     = s + m_bw;
      e_hs   = ((m_pos < 64) ? 1 : 0) ^ m_inv;             // R3 R4
      e_ref  = (m_pos != MAXP && m_pos >= s && m_pos < s + m_disp) ? 1 : 0;  // R5 R9 R11
      in_act = (m_pos >= rs + m_trim) && (m_pos + m_trim < rs + m_act);      // R7
      e_act  = (e_ref == 1 && in_act) ? 1 : 0;             // R8
      e_sel  = (e_ref == 1 && !in_act) ? 1 : 0;            // R6
      rise    = s2 && !s3;
      restart = free_run ? (m_pos + 1 >= m_len) : rise;    // R1 R2
      s3 = s2; s2 = s1; s1 = hsync_in;
      if (restart) begin m_pos = 0; capture(); end         // R10
      else if (m_pos != MAXP) m_pos++;                     // R9
    end
    check("hsync_o R3 R4", hsync_o, e_hs);
    check("lref_o R5", lref_o, e_ref);
    check("act_o R7 R8", act_o, e_act);
    check("bdr_sel_o R6", bdr_sel_o, e_sel);
    check("bdr_y_o R6", bdr_y_o, e_sel ? m_y_out() : 0);
    check("bdr_u_o R6", bdr_u_o, e_sel ? m_u_prev : 0);
    check("bdr_v_o R6", bdr_v_o, e_sel ? m_v_prev : 0);
    m_y_prev = m_y; m_u_prev = m_u; m_v_prev = m_v;
  endtask

  // Colour values valid for the edge just modelled (settings before any restart).
  int m_y_prev, m_u_prev, m_v_prev;
  function automatic int m_y_out();
    return m_y_prev;
  endfunction

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    rst = 1; hsync_in = 0; free_run = 1; sync_inv = 1;
    line_len = 100; ref_delay = 0; disp_len = 40; border_w = 0;
    act_len = 30; trim = 0; bdr_y_in = 8'h10; bdr_u_in = 8'h80; bdr_v_in = 8'h81;
    m_y_prev = 0; m_u_prev = 0; m_v_prev = 0;
    capture();
    m_y_prev = m_y; m_u_prev = m_u; m_v_prev = m_v;

    // R12: reset levels with inverted polarity, then with normal polarity.
    scen = "R12";
    run(3);
    sync_inv = 0;
    run(2);
    rst = 0;

    // R2 R10 R11: free-running sweep, settings changed at arbitrary positions.
    scen = "R2 R10 R11";
    begin
      int lens[2]  = '{100, 150};
      int dlys[2]  = '{0, 60};
      int disps[2] = '{40, 80};
      int bws[2]   = '{0, 7};
      int acts[2]  = '{30, 50};
      int trims[3] = '{0, 3, 20};
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
          for (int c = 0; c < 2; c++)
            for (int d = 0; d < 2; d++)
              for (int e = 0; e < 2; e++)
                for (int f = 0; f < 3; f++)
                  for (int g = 0; g < 2; g++) begin
                    line_len = W'(lens[a]); ref_delay = W'(dlys[b]); disp_len = W'(disps[c]);
                    border_w = W'(bws[d]);  act_len = W'(acts[e]);   trim = W'(trims[f]);
                    sync_inv = g[0];
                    bdr_y_in = C'(a * 16 + f); bdr_u_in = C'(100 + b * 9 + e); bdr_v_in = C'(200 + c + d);
                    run(2 * lens[a] + 17);
                  end
    end

    // R1: locked to input syncs of varied spacing and pulse width.
    scen = "R1";
    free_run = 0; line_len = 100; ref_delay = 10; disp_len = 60; border_w = 5;
    act_len = 40; trim = 2; sync_inv = 0;
    begin
      int gaps[5]  = '{120, 90, 200, 70, 160};
      int width[5] = '{1, 3, 5, 2, 1};
      for (int k = 0; k < 5; k++) begin
        hsync_in = 1; run(width[k]);
        hsync_in = 0; run(gaps[k] - width[k]);
        sync_inv = ~sync_inv;
      end
    end

    // R9: no input sync, counter parks and strobes stay low.
    scen = "R9";
    run(MAXP + 60);
    hsync_in = 1; run(2); hsync_in = 0; run(150);

    // R9 R2: park again, then release into free-running mode.
    run(MAXP + 10);
    free_run = 1; line_len = 120;
    run(400);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule